// File: doc/BRIEF.md
# ATA Task-File Command Issuer

This block starts one single-sector ATA command on a CompactFlash card by programming the card's task-file registers over a simple synchronous register bus. The command is read sector, write sector or identify. It is a bus master. It first polls the status register until the card is idle. It then writes the sector count, the 28-bit LBA split across the address registers, the drive/head byte with the LBA-mode bits set, and last the command code. After that it polls status again until the command is accepted or the card reports a fault. The data phase that follows belongs to other logic.

A static mode input selects one of three ways to reach the registers:
- **Byte mode:** a plain 8-bit register file.
- **Paired-word mode:** a 16-bit bus on which two adjacent registers share one word, so the setup needs only three word writes.
- **True IDE mode:** 8-bit registers sit on a 16-bit bus, one register per word, and only the low byte is meaningful.

Between successive status reads the block waits a programmable number of idle cycles. If the card stays busy for too many polls before the command, the block gives up and reports that no card is present.

Top module: `tfcmd_issuer`

## Requirements
- R1: After reset, `busy_o`, `bus_req_o`, `bus_we_o`, `done_o`, `fault_o` and `absent_o` are all low.
- R2: A start first reads status (offset 7: address 7 in byte and True IDE modes, word address 3 in paired-word mode). No write is issued while the status read shows BSY (bit 7) set.
- R3: After any status read that shows BSY, the block keeps `bus_req_o` low for exactly `POLL_GAP` cycles before the next status read.
- R4: If `POLL_LIMIT` consecutive pre-command status reads all show BSY, the block pulses `absent_o` and issues no write.
- R5: In byte mode (`mode_i`=0) the block makes six writes, to addresses 2,3,4,5,6,7 in that order. The low byte carries, in the same order: 0x01, LBA[7:0], LBA[15:8], LBA[23:16], 0xE0|LBA[27:24], and the command. The high byte is 0.
- R6: In paired-word mode (`mode_i`=1 or 3) the block makes three writes: word 1 = {LBA[7:0],0x01}, word 2 = {LBA[23:16],LBA[15:8]}, word 3 = {cmd,0xE0|LBA[27:24]}. Status is taken from the high byte of word 3.
- R7: In True IDE mode (`mode_i`=2) the writes match R5, and status is taken from the low byte only. The high byte of read data has no effect.
- R8: A post-command status read with BSY clear ends the command with a `done_o` pulse, whatever the DRQ and DF bits show.
- R9: A post-command status read with BSY and DF (bit 5) both set ends the command with a `fault_o` pulse.
- R10: A post-command status read with BSY set and DF clear leads to another status read.
- R11: `start_i` has no effect while `busy_o` is high.
- R12: `done_o`, `fault_o` and `absent_o` are one-cycle pulses, at most one at a time. `busy_o` is already low in the pulse cycle.
- R13: Once `bus_req_o` is raised, it stays high and `bus_addr_o`, `bus_we_o` and `bus_wdata_o` stay stable until a cycle with `bus_ack_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a command (sampled only when idle) |
| mode_i | input | 2 | Bus mode: 0 byte, 1/3 paired word, 2 True IDE |
| cmd_i | input | 8 | ATA command code |
| lba_i | input | 28 | Logical block address |
| bus_req_o | output | 1 | Register-bus strobe |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 3 | Register (byte/True IDE) or word (paired) address |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Transfer acknowledge |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Pulse: command accepted |
| fault_o | output | 1 | Pulse: device fault while busy |
| absent_o | output | 1 | Pulse: card never became idle |

## Verification
A wrong sequencer state shows at the bus port no later than the next handshake. Examples are a skipped pre-poll, a step index off by one, or a wrong byte-lane choice. Each one appears as an out-of-order address, a wrong data byte, or a write issued while BSY was reported. A wrong poll-gap or poll-count value shows as a status read arriving one gap early or late, or as the absent pulse arriving one poll early or late. A wrong status decode shows within one status read, as the wrong one of done, fault or absent, or as a missing or extra poll.

// File: rtl/tfcmd_pkg.sv
package tfcmd_pkg;
  localparam int LBA_W  = 28;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;
  localparam int STEP_W = 3;

  typedef enum logic [1:0] {
    MODE_BYTE     = 2'd0,
    MODE_PAIR     = 2'd1,
    MODE_TIDE     = 2'd2,
    MODE_PAIR_ALT = 2'd3
  } bus_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PRE_RD   = 3'd1,
    ST_PRE_GAP  = 3'd2,
    ST_WR       = 3'd3,
    ST_POST_RD  = 3'd4,
    ST_POST_GAP = 3'd5
  } seq_state_e;

  // task-file byte offsets the card decodes
  localparam logic [ADDR_W-1:0] OFS_SCNT = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd7;
  localparam logic [3:0]        DRVH_TOP = 4'hE;
  localparam logic [7:0]        ONE_SECTOR = 8'h01;
  localparam int BIT_BSY = 7;
  localparam int BIT_DF  = 5;

  // modes 1 and 3 share a word between two registers
  function automatic logic is_paired(bus_mode_e m);
    return m[0];
  endfunction
endpackage

// File: rtl/tfcmd_pacer.sv
module tfcmd_pacer #(
  parameter int POLL_GAP = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(POLL_GAP - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = RELOAD;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/tfcmd_lane.sv
module tfcmd_lane
  import tfcmd_pkg::*;
(
  input  bus_mode_e           mode_i,
  input  logic                rd_i,
  input  logic [STEP_W-1:0]   step_i,
  input  logic [7:0]          cmd_i,
  input  logic [LBA_W-1:0]    lba_i,
  input  logic [DATA_W-1:0]   rdata_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W-1:0]   wdata_o,
  output logic                bsy_o,
  output logic                df_o
);
  logic [7:0] seq_b [8];
  logic       pair;
  logic [7:0] stat;
  logic [2:0] idx_lo, idx_hi;

  always_comb begin
    seq_b[0] = ONE_SECTOR;
    seq_b[1] = lba_i[7:0];
    seq_b[2] = lba_i[15:8];
    seq_b[3] = lba_i[23:16];
    seq_b[4] = {DRVH_TOP, lba_i[27:24]};
    seq_b[5] = cmd_i;
    seq_b[6] = 8'h00;
    seq_b[7] = 8'h00;
  end

  assign pair   = is_paired(mode_i);
  assign idx_lo = {step_i[1:0], 1'b0};
  assign idx_hi = {step_i[1:0], 1'b1};

  always_comb begin
    if (rd_i) begin
      addr_o  = pair ? (OFS_STAT >> 1) : OFS_STAT;
      wdata_o = '0;
    end else if (pair) begin
      addr_o  = (OFS_SCNT >> 1) + step_i;
      wdata_o = {seq_b[idx_hi], seq_b[idx_lo]};
    end else begin
      addr_o  = OFS_SCNT + step_i;
      wdata_o = {8'h00, seq_b[step_i]};
    end
  end

  assign stat  = pair ? rdata_i[15:8] : rdata_i[7:0];
  assign bsy_o = stat[BIT_BSY];
  assign df_o  = stat[BIT_DF];
endmodule

// File: rtl/tfcmd_seq.sv
module tfcmd_seq
  import tfcmd_pkg::*;
#(
  parameter int POLL_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ack_i,
  input  logic              bsy_i,
  input  logic              df_i,
  input  logic              pair_i,
  input  logic              gap_exp_i,
  output logic              rd_o,
  output logic              wr_o,
  output logic              latch_o,
  output logic              gap_load_o,
  output logic              gap_run_o,
  output logic [STEP_W-1:0] step_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic              absent_o
);
  localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [PW-1:0]     POLL_LAST = PW'(POLL_LIMIT - 1);
  localparam logic [STEP_W-1:0] LAST_PAIR = 3'd2;
  localparam logic [STEP_W-1:0] LAST_BYTE = 3'd5;

  seq_state_e        st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [PW-1:0]     polls_q, polls_d;
  logic              done_q, fault_q, absent_q;
  logic              done_d, fault_d, absent_d;
  logic              last_step;

  assign last_step = (step_q == (pair_i ? LAST_PAIR : LAST_BYTE));

  always_comb begin
    st_d       = st_q;
    step_d     = step_q;
    polls_d    = polls_q;
    done_d     = 1'b0;
    fault_d    = 1'b0;
    absent_d   = 1'b0;
    gap_load_o = 1'b0;
    latch_o    = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        latch_o = 1'b1;
        polls_d = '0;
        step_d  = '0;
        st_d    = ST_PRE_RD;
      end
      ST_PRE_RD: if (ack_i) begin
        if (bsy_i) begin
          if (polls_q == POLL_LAST) begin
            absent_d = 1'b1;
            st_d     = ST_IDLE;
          end else begin
            polls_d    = polls_q + 1'b1;
            gap_load_o = 1'b1;
            st_d       = ST_PRE_GAP;
          end
        end else begin
          step_d = '0;
          st_d   = ST_WR;
        end
      end
      ST_PRE_GAP: if (gap_exp_i) st_d = ST_PRE_RD;
      ST_WR: if (ack_i) begin
        if (last_step) st_d = ST_POST_RD;
        else           step_d = step_q + 1'b1;
      end
      ST_POST_RD: if (ack_i) begin
        if (bsy_i && df_i) begin
          fault_d = 1'b1;
          st_d    = ST_IDLE;
        end else if (bsy_i) begin
          gap_load_o = 1'b1;
          st_d       = ST_POST_GAP;
        end else begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      ST_POST_GAP: if (gap_exp_i) st_d = ST_POST_RD;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      step_q   <= '0;
      polls_q  <= '0;
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
      absent_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      step_q   <= step_d;
      polls_q  <= polls_d;
      done_q   <= done_d;
      fault_q  <= fault_d;
      absent_q <= absent_d;
    end
  end

  assign rd_o      = (st_q == ST_PRE_RD) || (st_q == ST_POST_RD);
  assign wr_o      = (st_q == ST_WR);
  assign gap_run_o = (st_q == ST_PRE_GAP) || (st_q == ST_POST_GAP);
  assign step_o    = step_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign fault_o   = fault_q;
  assign absent_o  = absent_q;
endmodule

// File: rtl/tfcmd_issuer.sv
module tfcmd_issuer
  import tfcmd_pkg::*;
#(
  parameter int POLL_GAP   = 1000,
  parameter int POLL_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [7:0]        cmd_i,
  input  logic [LBA_W-1:0]  lba_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic              absent_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_loc_n;
  bus_mode_e         mode_q;
  logic [7:0]        cmd_q;
  logic [LBA_W-1:0]  lba_q;
  logic              latch, rd, wr, gap_load, gap_run, gap_exp;
  logic              bsy, df;
  logic [STEP_W-1:0] step;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_loc_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_loc_n) begin
    if (!rst_loc_n) begin
      mode_q <= MODE_BYTE;
      cmd_q  <= '0;
      lba_q  <= '0;
    end else if (latch) begin
      mode_q <= bus_mode_e'(mode_i);
      cmd_q  <= cmd_i;
      lba_q  <= lba_i;
    end
  end

  tfcmd_seq #(.POLL_LIMIT(POLL_LIMIT)) u_seq (
    .clk(clk), .rst_n(rst_loc_n), .start_i(start_i), .ack_i(bus_ack_i),
    .bsy_i(bsy), .df_i(df), .pair_i(is_paired(mode_q)), .gap_exp_i(gap_exp),
    .rd_o(rd), .wr_o(wr), .latch_o(latch), .gap_load_o(gap_load),
    .gap_run_o(gap_run), .step_o(step), .busy_o(busy_o), .done_o(done_o),
    .fault_o(fault_o), .absent_o(absent_o)
  );

  tfcmd_pacer #(.POLL_GAP(POLL_GAP)) u_pacer (
    .clk(clk), .rst_n(rst_loc_n), .load_i(gap_load), .run_i(gap_run),
    .expired_o(gap_exp)
  );

  tfcmd_lane u_lane (
    .mode_i(mode_q), .rd_i(rd), .step_i(step), .cmd_i(cmd_q), .lba_i(lba_q),
    .rdata_i(bus_rdata_i), .addr_o(bus_addr_o), .wdata_o(bus_wdata_o),
    .bsy_o(bsy), .df_o(df)
  );

  assign bus_req_o = rd | wr;
  assign bus_we_o  = wr;
endmodule

// File: rtl/tfcmd_issuer_chk.sv
module tfcmd_issuer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        bus_req_o,
  input logic        bus_we_o,
  input logic [2:0]  bus_addr_o,
  input logic [15:0] bus_wdata_o,
  input logic        bus_ack_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        fault_o,
  input logic        absent_o
);
  logic any_end;
  assign any_end = done_o | fault_o | absent_o;

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o)
                                && $stable(bus_we_o) && $stable(bus_wdata_o));

  p_one_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, fault_o, absent_o}));

  p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    any_end |=> !any_end);

  p_quiet_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    any_end |-> !busy_o && !bus_req_o);

  p_idle_noreq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_req_o);

  p_first_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> bus_req_o && !bus_we_o);
endmodule

bind tfcmd_issuer tfcmd_issuer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .bus_req_o(bus_req_o),
  .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
  .bus_ack_i(bus_ack_i), .busy_o(busy_o), .done_o(done_o),
  .fault_o(fault_o), .absent_o(absent_o)
);

// File: tb/tfcmd_issuer_test.sv
module tfcmd_issuer_test;
  localparam int GAP   = 3;
  localparam int LIMIT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [7:0]  cmd_i = 8'h00;
  logic [27:0] lba_i = '0;
  logic        bus_req_o, bus_we_o;
  logic [2:0]  bus_addr_o;
  logic [15:0] bus_wdata_o;
  logic [15:0] bus_rdata_i = '0;
  logic        bus_ack_i = 1'b0;
  logic        busy_o, done_o, fault_o, absent_o;

  always #5 clk = ~clk;

  tfcmd_issuer #(.POLL_GAP(GAP), .POLL_LIMIT(LIMIT)) uut (.*);

  typedef struct packed { logic we; logic [2:0] addr; logic [15:0] data; } xfer_t;
  xfer_t       exp_q[$];
  string       tag_q[$];
  logic [15:0] rd_q[$];
  logic [1:0]  cur_mode = 2'd0;
  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push_rd(input string tag);
    exp_q.push_back({1'b0, (cur_mode[0] ? 3'd3 : 3'd7), 16'h0000});
    tag_q.push_back(tag);
  endtask

  task automatic push_wr(input logic [2:0] a, input logic [15:0] d, input string tag);
    exp_q.push_back({1'b1, a, d});
    tag_q.push_back(tag);
  endtask

  // monitor / responder: one wait cycle per transfer, compares against scoreboard
  initial begin
    xfer_t cap, e;
    string t;
    bit seen = 0, prev_busy = 0;
    int idle = 0;
    logic [15:0] w;
    forever begin
      @(negedge clk);
      if (!busy_o) begin prev_busy = 0; idle = 0; end
      else if (!bus_req_o) idle++;
      if (bus_ack_i) bus_ack_i = 1'b0;
      else if (bus_req_o) begin
        if (!seen) begin
          cap = {bus_we_o, bus_addr_o, bus_wdata_o};
          seen = 1;
        end else begin
          seen = 0;
          check(cap == {bus_we_o, bus_addr_o, bus_wdata_o}, "R13", "held request",
                {13'd0, bus_we_o, bus_addr_o, bus_wdata_o}, {13'd0, cap});
          if (exp_q.size() == 0) begin
            check(0, "R11", "unexpected transfer", {13'd0, bus_we_o, bus_addr_o, bus_wdata_o}, 0);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(e.we == bus_we_o && e.addr == bus_addr_o &&
                  (!e.we || e.data == bus_wdata_o), t, "transfer",
                  {13'd0, bus_we_o, bus_addr_o, bus_wdata_o}, {13'd0, e});
          end
          if (!bus_we_o) begin
            if (prev_busy) check(idle == GAP, "R3", "poll gap", idle, GAP);
            w = (rd_q.size() != 0) ? rd_q.pop_front() : 16'h0000;
            bus_rdata_i = w;
            prev_busy = cur_mode[0] ? w[15] : w[7];
          end else prev_busy = 0;
          idle = 0;
          bus_ack_i = 1'b1;
        end
      end
    end
  end

  // outc: 0 done (R8), 1 fault (R9), 2 absent (R4)
  task automatic run_op(input logic [1:0] m, input logic [7:0] c, input logic [27:0] l,
                        input int npre, input int npost, input int outc, input bit inject);
    logic [7:0] b [6];
    int got, reqs;
    string otag;
    otag = (outc == 0) ? "R8" : (outc == 1) ? "R9" : "R4";
    cur_mode = m;
    b[0] = 8'h01; b[1] = l[7:0]; b[2] = l[15:8]; b[3] = l[23:16];
    b[4] = {4'hE, l[27:24]}; b[5] = c;
    for (int i = 0; i < npre; i++) push_rd("R2");
    if (outc != 2) begin
      if (m[0]) begin
        push_wr(3'd1, {b[1], b[0]}, "R6");
        push_wr(3'd2, {b[3], b[2]}, "R6");
        push_wr(3'd3, {b[5], b[4]}, "R6");
      end else begin
        for (int i = 0; i < 6; i++)
          push_wr(3'(2 + i), {8'h00, b[i]}, (m == 2'd2) ? "R7" : "R5");
      end
      for (int i = 0; i < npost; i++) push_rd("R10");
    end
    @(negedge clk);
    start_i = 1'b1; mode_i = m; cmd_i = c; lba_i = l;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (done_o | fault_o | absent_o) break;
      @(negedge clk);
      start_i = inject && (i == 4);   // R11: start while busy
      if (inject && i == 4) begin cmd_i = 8'h30; mode_i = 2'd0; end
    end
    got = done_o ? 0 : fault_o ? 1 : absent_o ? 2 : 3;
    check(got == outc, otag, "outcome", got, outc);
    check(!busy_o, "R12", "busy low with pulse", busy_o, 0);
    check(exp_q.size() == 0 && rd_q.size() == 0, otag, "all transfers seen",
          exp_q.size(), 0);
    exp_q.delete(); tag_q.delete(); rd_q.delete();
    @(negedge clk);
    start_i = 1'b0;
    check(!(done_o | fault_o | absent_o), "R12", "pulse width",
          {done_o, fault_o, absent_o}, 0);
    reqs = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); reqs += bus_req_o; end
    check(reqs == 0, "R11", "no extra command", reqs, 0);
  endtask

  initial begin
    #(10 * 150000);
    check(0, "WDOG", "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check({busy_o, bus_req_o, bus_we_o, done_o, fault_o, absent_o} == 6'b0, "R1",
          "reset outputs", {busy_o, bus_req_o, bus_we_o, done_o, fault_o, absent_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy_o && !bus_req_o, "R1", "idle after release", {busy_o, bus_req_o}, 0);

    // byte mode: two busy pre-polls, post busy, busy+DRQ, then DF+DRQ with BSY clear
    rd_q = '{16'h0080, 16'h0080, 16'h0050, 16'h0080, 16'h0088, 16'h0028};
    run_op(2'd0, 8'h20, 28'h5A3C1E7, 3, 3, 0, 0);

    // paired: low byte busy ignored; post busy then busy+DF
    rd_q = '{16'h0080, 16'h8000, 16'hA000};
    run_op(2'd1, 8'h30, 28'hFFFFFFF, 1, 2, 1, 0);

    // True IDE: high byte busy ignored; start injected while busy
    rd_q = '{16'h8050, 16'h0080, 16'hFF08};
    run_op(2'd2, 8'hEC, 28'h0000000, 1, 2, 0, 1);

    // byte mode card absent
    rd_q = '{16'h0080, 16'h0080, 16'h0080, 16'h0080};
    run_op(2'd0, 8'h20, 28'h0000001, LIMIT, 0, 2, 0);

    // mode 3 behaves as paired; DF alone with BSY clear completes
    rd_q = '{16'h5000, 16'h2000};
    run_op(2'd3, 8'h20, 28'h1234567, 1, 1, 0, 0);

    // paired absent: high byte busy, low byte idle
    rd_q = '{16'h8000, 16'h8000, 16'h8000, 16'h8000};
    run_op(2'd1, 8'hEC, 28'h7654321, LIMIT, 0, 2, 0);

    // byte mode, no waits at all
    rd_q = '{16'h0000, 16'h0040};
    run_op(2'd0, 8'hEC, 28'hABCDEF0, 1, 1, 0, 0);

    // True IDE fault
    rd_q = '{16'h0000, 16'h00A8};
    run_op(2'd2, 8'h30, 28'h0F0F0F0, 1, 1, 1, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule